// File: doc/BRIEF.md
# Display Power Mode Sequencer

This block steps a display power subsystem through six operating modes: off, standby, powering, ready, parking and shutdown. A request from the system asks for power on or power off. The request passes through a synchronizer and a debounce filter before the controller acts on it. While powering up, the block turns the supply rails on one at a time and waits for each rail's good flag. Once every rail is good, it reports that it is ready.

Trouble in the ready mode never cuts power at once. A supply brownout, a rail undervoltage or a power-off request first sends the controller into a parking phase, which asks the mirror array to park. Rail shutdown starts only after parking is acknowledged. The rails then drop one per cycle, highest index first, and the block flags that power may be removed. A new power-up from shutdown needs the request to be seen low and then high again.

The block has an asynchronous active-low reset that comes from the main supply monitor. The analog comparators, the regulators and the rail converter are outside the block and appear here as plain digital inputs.

Top module: `pwr_mode_seq`

## Requirements
- R1: While `rst_n` is low, with no clock edge needed: `mode_o` is 0 (off), all `rail_en_o` bits are 0, and `park_req_o`, `ready_o` and `off_ready_o` are 0.
- R2: `on_req_i` (1 = on) goes through a two-flop synchronizer and a 4-cycle debounce. A change is acted on 7 rising edges after it is applied: the mode leaves off on that edge. A pulse of 3 cycles is ignored. The request is not sampled during reset, so a request held high through reset still takes 7 edges after release.
- R3: In standby the controller moves to powering on the next edge if the filtered request is high and `brownout_i` is low. While `brownout_i` is high it stays in standby with all rails off.
- R4: Powering starts with `rail_en_o` = 1 (rail 0 only). On each edge where the good flag of the newest enabled rail is high, the next rail in index order is enabled, so the enables always form a run of ones from bit 0 upward. On the edge after the last rail is good, the mode becomes ready, with all enables set.
- R5: If the newest enabled rail is not good within `TIMEOUT_CYCLES` edges of being enabled, the mode becomes parking on that edge. The rails already enabled stay enabled.
- R6: `pwr_fault_o` is the combinational OR of all `rail_uv_i` bits.
- R7: In ready, `ready_o` is 1. Any of `brownout_i` high, `pwr_fault_o` high, or a filtered request low moves the mode to parking on the next edge.
- R8: In parking, `park_req_o` is 1 and the rail enables do not change. The mode stays in parking until `park_done_i` is high, then moves to shutdown on the next edge.
- R9: In shutdown, the highest enabled rail is dropped on each edge (`rail_en_o` shifts right by one). `off_ready_o` is 1 exactly when the mode is shutdown and all rails are off.
- R10: Shutdown is left for standby only after the filtered request has been seen low while in shutdown and is then high. A request held high throughout keeps the mode in shutdown.
- R11: `mode_o` encoding: 0 off, 1 standby, 2 powering, 3 ready, 4 parking, 5 shutdown.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset from the main supply monitor |
| on_req_i | input | 1 | Asynchronous power request, 1 = on |
| brownout_i | input | 1 | Main supply brownout comparator flag |
| rail_uv_i | input | N_RAILS | Per-rail undervoltage flags |
| rail_good_i | input | N_RAILS | Per-rail good flags from the regulators |
| park_done_i | input | 1 | Mirror park acknowledge |
| rail_en_o | output | N_RAILS | Rail enable strobes, bit 0 first on |
| park_req_o | output | 1 | Mirror park request |
| ready_o | output | 1 | Subsystem ready for display |
| off_ready_o | output | 1 | All rails off, power may be removed |
| pwr_fault_o | output | 1 | OR of all rail undervoltage flags |
| mode_o | output | 3 | Current operating mode |

## Verification
The bench sweeps the stalled rail over every index. A wrong timeout compare would park one cycle early or late, and an off-by-one in the rail count would leave the wrong enable pattern when parking begins. It raises each undervoltage bit alone while in ready, so a fault OR that misses a bit would leave the system displaying on a failed rail. It holds brownout both before standby and during ready, holds park-done low for several cycles, and keeps the request high after shutdown. A design that skipped any of these gates would start regulators on a collapsing supply, cut rails under unparked mirrors, or restart on its own. A 3-cycle request glitch and a request held through reset check that the filter neither passes noise nor samples early.

// File: rtl/pms_pkg.sv
package pms_pkg;
   typedef enum logic [2:0] {
      MODE_OFF      = 3'd0,
      MODE_STANDBY  = 3'd1,
      MODE_POWERING = 3'd2,
      MODE_READY    = 3'd3,
      MODE_PARKING  = 3'd4,
      MODE_SHUTDOWN = 3'd5
   } pms_mode_e;
endpackage

// File: rtl/pms_in_filter.sv
module pms_in_filter #(
   parameter int SYNC_STAGES     = 2,
   parameter int DEBOUNCE_CYCLES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw_i,
   output logic filt_o
);
   logic [SYNC_STAGES-1:0] sync_q;
   logic                   synced;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '0;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
   end
   assign synced = sync_q[SYNC_STAGES-1];

   generate
      if (DEBOUNCE_CYCLES <= 1) begin : g_nodb
         assign filt_o = synced;
      end else begin : g_db
         localparam int CW = $clog2(DEBOUNCE_CYCLES);
         localparam logic [CW-1:0] CNT_LAST = CW'(DEBOUNCE_CYCLES - 1);
         logic [CW-1:0] cnt_q;
         logic          filt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q  <= '0;
               filt_q <= 1'b0;
            end else if (synced == filt_q) begin
               cnt_q <= '0;
            end else if (cnt_q == CNT_LAST) begin
               cnt_q  <= '0;
               filt_q <= synced;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
         assign filt_o = filt_q;
      end
   endgenerate
endmodule

// File: rtl/pms_fault_merge.sv
module pms_fault_merge #(
   parameter int N_RAILS = 4
) (
   input  logic [N_RAILS-1:0] uv_i,
   output logic               fault_o
);
   assign fault_o = |uv_i;
endmodule

// File: rtl/pms_fsm.sv
module pms_fsm
   import pms_pkg::*;
#(
   parameter int N_RAILS        = 4,
   parameter int TIMEOUT_CYCLES = 64
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               on_i,
   input  logic               brownout_i,
   input  logic               fault_i,
   input  logic [N_RAILS-1:0] rail_good_i,
   input  logic               park_done_i,
   output logic [N_RAILS-1:0] rail_en_o,
   output logic               park_req_o,
   output logic               ready_o,
   output logic               off_ready_o,
   output logic [2:0]         mode_o
);
   localparam int IW = $clog2(N_RAILS);
   localparam int TW = $clog2(TIMEOUT_CYCLES + 1);
   localparam logic [IW-1:0] IDX_LAST = IW'(N_RAILS - 1);
   localparam logic [TW-1:0] TMR_LAST = TW'(TIMEOUT_CYCLES - 1);
   localparam logic [N_RAILS-1:0] FIRST_RAIL = N_RAILS'(1);

   pms_mode_e          state_q, state_d;
   logic [N_RAILS-1:0] en_q, en_d;
   logic [IW-1:0]      idx_q, idx_d;
   logic [TW-1:0]      tmr_q, tmr_d;
   logic               seen_low_q, seen_low_d;

   always_comb begin
      state_d    = state_q;
      en_d       = en_q;
      idx_d      = idx_q;
      tmr_d      = tmr_q;
      seen_low_d = seen_low_q;
      case (state_q)
         MODE_OFF: begin
            if (on_i) state_d = MODE_STANDBY;
         end
         MODE_STANDBY: begin
            if (!on_i) begin
               state_d = MODE_OFF;
            end else if (!brownout_i) begin
               state_d = MODE_POWERING;
               en_d    = FIRST_RAIL;
               idx_d   = '0;
               tmr_d   = '0;
            end
         end
         MODE_POWERING: begin
            if (brownout_i || !on_i) begin
               state_d = MODE_PARKING;
            end else if (rail_good_i[idx_q]) begin
               tmr_d = '0;
               if (idx_q == IDX_LAST) begin
                  state_d = MODE_READY;
               end else begin
                  idx_d = idx_q + 1'b1;
                  en_d  = {en_q[N_RAILS-2:0], 1'b1};
               end
            end else if (tmr_q == TMR_LAST) begin
               state_d = MODE_PARKING;
            end else begin
               tmr_d = tmr_q + 1'b1;
            end
         end
         MODE_READY: begin
            if (brownout_i || fault_i || !on_i) state_d = MODE_PARKING;
         end
         MODE_PARKING: begin
            if (park_done_i) begin
               state_d    = MODE_SHUTDOWN;
               seen_low_d = 1'b0;
            end
         end
         MODE_SHUTDOWN: begin
            if (!on_i) seen_low_d = 1'b1;
            if (en_q != '0) begin
               en_d = en_q >> 1;
            end else if (on_i && seen_low_q) begin
               state_d = MODE_STANDBY;
            end
         end
         default: state_d = MODE_OFF;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= MODE_OFF;
         en_q       <= '0;
         idx_q      <= '0;
         tmr_q      <= '0;
         seen_low_q <= 1'b0;
      end else begin
         state_q    <= state_d;
         en_q       <= en_d;
         idx_q      <= idx_d;
         tmr_q      <= tmr_d;
         seen_low_q <= seen_low_d;
      end
   end

   assign rail_en_o   = en_q;
   assign park_req_o  = (state_q == MODE_PARKING);
   assign ready_o     = (state_q == MODE_READY);
   assign off_ready_o = (state_q == MODE_SHUTDOWN) && (en_q == '0);
   assign mode_o      = state_q;
endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq #(
   parameter int N_RAILS         = 4,
   parameter int SYNC_STAGES     = 2,
   parameter int DEBOUNCE_CYCLES = 4,
   parameter int TIMEOUT_CYCLES  = 64
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               on_req_i,
   input  logic               brownout_i,
   input  logic [N_RAILS-1:0] rail_uv_i,
   input  logic [N_RAILS-1:0] rail_good_i,
   input  logic               park_done_i,
   output logic [N_RAILS-1:0] rail_en_o,
   output logic               park_req_o,
   output logic               ready_o,
   output logic               off_ready_o,
   output logic               pwr_fault_o,
   output logic [2:0]         mode_o
);
   generate
      if (N_RAILS < 2 || N_RAILS > 16) begin : g_bad_rails
         $error("N_RAILS must lie in 2..16");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (TIMEOUT_CYCLES < 1) begin : g_bad_tmo
         $error("TIMEOUT_CYCLES must be at least 1");
      end
   endgenerate

   logic on_filt;
   logic fault;

   pms_in_filter #(
      .SYNC_STAGES    (SYNC_STAGES),
      .DEBOUNCE_CYCLES(DEBOUNCE_CYCLES)
   ) u_filter (
      .clk   (clk),
      .rst_n (rst_n),
      .raw_i (on_req_i),
      .filt_o(on_filt)
   );

   pms_fault_merge #(.N_RAILS(N_RAILS)) u_fault (
      .uv_i   (rail_uv_i),
      .fault_o(fault)
   );

   pms_fsm #(
      .N_RAILS       (N_RAILS),
      .TIMEOUT_CYCLES(TIMEOUT_CYCLES)
   ) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .on_i       (on_filt),
      .brownout_i (brownout_i),
      .fault_i    (fault),
      .rail_good_i(rail_good_i),
      .park_done_i(park_done_i),
      .rail_en_o  (rail_en_o),
      .park_req_o (park_req_o),
      .ready_o    (ready_o),
      .off_ready_o(off_ready_o),
      .mode_o     (mode_o)
   );

   assign pwr_fault_o = fault;
endmodule

// File: rtl/pwr_mode_seq_chk.sv
module pwr_mode_seq_chk #(
   parameter int N_RAILS = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               brownout_i,
   input logic               park_done_i,
   input logic [N_RAILS-1:0] rail_en_o,
   input logic               park_req_o,
   input logic               ready_o,
   input logic               off_ready_o,
   input logic               pwr_fault_o,
   input logic [2:0]         mode_o
);
   localparam logic [N_RAILS-1:0] ONE = N_RAILS'(1);

   AST_PARK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == 3'd4 && !park_done_i) |=> (mode_o == 3'd4 && park_req_o)); // R8

   AST_PARK_RAILS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == 3'd4 && $past(mode_o) == 3'd4) |-> $stable(rail_en_o)); // R8

   AST_RAILS_THERMO: assert property (@(posedge clk) disable iff (!rst_n)
      ((rail_en_o + ONE) & rail_en_o) == '0); // R4

   AST_READY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      ready_o |-> (rail_en_o == '1)); // R4

   AST_READY_FAULT_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == 3'd3 && (pwr_fault_o || brownout_i)) |=> (mode_o == 3'd4)); // R7

   AST_STANDBY_BROWNOUT: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == 3'd1 && brownout_i) |=> (mode_o != 3'd2)); // R3

   AST_SHUT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == 3'd5 && rail_en_o != '0) |=> (rail_en_o == ($past(rail_en_o) >> 1))); // R9

   AST_SHUT_VIA_PARK: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == 3'd5 && $past(mode_o) != 3'd5) |-> ($past(mode_o) == 3'd4)); // R8

   AST_OFF_READY_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
      off_ready_o |-> (rail_en_o == '0 && !park_req_o && mode_o == 3'd5)); // R9
endmodule

bind pwr_mode_seq pwr_mode_seq_chk #(.N_RAILS(N_RAILS)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .brownout_i (brownout_i),
   .park_done_i(park_done_i),
   .rail_en_o  (rail_en_o),
   .park_req_o (park_req_o),
   .ready_o    (ready_o),
   .off_ready_o(off_ready_o),
   .pwr_fault_o(pwr_fault_o),
   .mode_o     (mode_o)
);

// File: tb/pwr_mode_seq_tb.sv
module pwr_mode_seq_tb;
   localparam int N  = 4;
   localparam int TO = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         on_req = 1'b0;
   logic         brownout = 1'b0;
   logic [N-1:0] rail_uv = '0;
   logic [N-1:0] good_mask = '1;
   logic [N-1:0] rail_good;
   logic         park_done = 1'b0;
   logic [N-1:0] rail_en;
   logic         park_req, ready, off_ready, pwr_fault;
   logic [2:0]   mode;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   assign rail_good = rail_en & good_mask;

   pwr_mode_seq #(
      .N_RAILS(N), .SYNC_STAGES(2), .DEBOUNCE_CYCLES(4), .TIMEOUT_CYCLES(TO)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .on_req_i(on_req), .brownout_i(brownout),
      .rail_uv_i(rail_uv), .rail_good_i(rail_good), .park_done_i(park_done),
      .rail_en_o(rail_en), .park_req_o(park_req), .ready_o(ready),
      .off_ready_o(off_ready), .pwr_fault_o(pwr_fault), .mode_o(mode)
   );

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      tick(2);
      chk("R1 mode in reset", 32'(mode), 0);
      chk("R1 rails in reset", 32'(rail_en), 0);
      chk("R1 flags in reset", {park_req, ready, off_ready}, 0);
      rst_n = 1'b1;
   endtask

   // Request rises now; checks R2/R3/R4/R11 timing up to ready.
   task automatic on_to_ready(input logic [2:0] from_mode);
      on_req = 1'b1;
      tick(6);
      chk("R2 not yet acted on", 32'(mode), 32'(from_mode));
      tick(1);
      chk("R2 R10 R11 standby after 7 edges", 32'(mode), 1);
      tick(1);
      chk("R3 R11 powering", 32'(mode), 2);
      chk("R4 first rail only", 32'(rail_en), 1);
      for (int j = 1; j < N; j++) begin
         tick(1);
         chk("R4 next rail in order", 32'(rail_en), (32'd2 << j) - 1);
      end
      tick(1);
      chk("R4 R11 ready mode", 32'(mode), 3);
      chk("R7 ready flag", 32'(ready), 1);
   endtask

   // Mode is parking with w rails on; acknowledge and walk shutdown.
   task automatic park_and_shut(input int w);
      tick(3);
      chk("R8 parking held without ack", 32'(mode), 4);
      chk("R8 park request", 32'(park_req), 1);
      chk("R8 rails unchanged while parking", 32'(rail_en), (32'd1 << w) - 1);
      park_done = 1'b1;
      tick(1);
      chk("R8 shutdown after ack", 32'(mode), 5);
      chk("R8 park request drops", 32'(park_req), 0);
      park_done = 1'b0;
      for (int j = w - 1; j >= 0; j--) begin
         chk("R9 not off-ready yet", 32'(off_ready), 0);
         tick(1);
         chk("R9 reverse rail drop", 32'(rail_en), (32'd1 << j) - 1);
      end
      chk("R9 off-ready", 32'(off_ready), 1);
   endtask

   task automatic rearm();
      on_req = 1'b0;
      tick(8);
      on_to_ready(3'd5);
   endtask

   initial begin
      // R1/R2: request held high across reset
      on_req = 1'b1;
      do_reset();
      on_to_ready(3'd0);

      // R7 brownout in ready
      brownout = 1'b1;
      tick(1);
      chk("R7 brownout parks", 32'(mode), 4);
      park_and_shut(N);
      brownout = 1'b0;
      tick(12);
      chk("R10 held request keeps shutdown", 32'(mode), 5);
      rearm();

      // R6/R7 each rail fault in ready
      for (int r = 0; r < N; r++) begin
         rail_uv = N'(1) << r;
         #1;
         chk("R6 single fault bit", 32'(pwr_fault), 1);
         tick(1);
         chk("R7 fault parks", 32'(mode), 4);
         rail_uv = '0;
         park_and_shut(N);
         rearm();
      end

      // R7 power-off request in ready, R10 re-arm after seen low
      on_req = 1'b0;
      tick(6);
      chk("R7 ready until filtered low", 32'(mode), 3);
      tick(1);
      chk("R7 off request parks", 32'(mode), 4);
      park_and_shut(N);
      tick(2);
      on_to_ready(3'd5);

      // R1 asynchronous reset mid-operation
      @(negedge clk);
      #2;
      rst_n = 1'b0;
      #1;
      chk("R1 async mode clear", 32'(mode), 0);
      chk("R1 async rails clear", 32'(rail_en), 0);
      chk("R1 async ready clear", 32'(ready), 0);

      // R6 full sweep while off
      on_req = 1'b0;
      tick(1);
      rst_n = 1'b1;
      for (int v = 0; v < (1 << N); v++) begin
         rail_uv = N'(v);
         #1;
         chk("R6 fault OR sweep", 32'(pwr_fault), (v != 0) ? 1 : 0);
      end
      rail_uv = '0;

      // R2 glitch rejection
      tick(10);
      on_req = 1'b1;
      tick(3);
      on_req = 1'b0;
      tick(15);
      chk("R2 3-cycle pulse ignored", 32'(mode), 0);

      // R3 standby waits for brownout
      brownout = 1'b1;
      on_req = 1'b1;
      tick(7);
      chk("R3 standby entered", 32'(mode), 1);
      tick(5);
      chk("R3 held in standby by brownout", 32'(mode), 1);
      chk("R3 rails off in standby", 32'(rail_en), 0);
      brownout = 1'b0;
      tick(1);
      chk("R3 powering after brownout clears", 32'(mode), 2);

      // R5 timeout sweep over stalled rail index
      for (int k = 0; k < N; k++) begin
         on_req = 1'b0;
         good_mask = ~(N'(1) << k);
         do_reset();
         on_req = 1'b1;
         tick(8 + k);
         chk("R5 stalled rail enabled", 32'(rail_en), (32'd2 << k) - 1);
         tick(TO - 1);
         chk("R5 still powering before timeout", 32'(mode), 2);
         tick(1);
         chk("R5 timeout parks", 32'(mode), 4);
         park_and_shut(k + 1);
      end
      good_mask = '1;

      done = 1'b1;
   end

   initial begin
      fork
         begin
            wait (done);
         end
         begin
            repeat (200000) @(posedge clk);
            checks++;
            errors++;
            $display("FAIL watchdog actual hung expected done");
         end
      join_any
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule